// File: doc/BRIEF.md
# Configurable Approximate SATD/SAD Engine

This block scores how well an 8x8 predicted block matches an 8x8 block of original pixels. It forms the signed residual (original minus predicted) and reduces it to one number. A two-bit mode picks one of four metrics: the exact sum of absolute transformed differences (SATD) from a full two-dimensional Hadamard transform; two cheaper approximations that skip trailing columns of butterfly operators; and the plain sum of absolute differences (SAD).

The transform is six registered butterfly stages. Stages 1 to 3 work along each row and stages 4 to 6 work down each column. A skipped stage acts as the identity. Each block travels with its own mode. Once the last stage that block needs has run, its sum leaves the wide pipeline and rides a narrow scalar chain to the output. The registers of the stages it skips are never loaded, so they do not switch. The engine accepts a block on every cycle, modes may be mixed freely, and every result appears after the same fixed delay.

Top module: `satd_sad_engine`

## Requirements
- R1: With in_mode = 2'b00 the result is (S+1)>>1, where S is the sum of |C[u][v]| over the 2D transform C = H*D*H of the 8x8 residual D, and H[i][j] = -1 when popcount(i & j) is odd and +1 otherwise.
- R2: With in_mode = 2'b01 the column stages 4 to 6 are identity. S is the sum, over all rows, of the absolute values of the 8-point Hadamard transform of that row, and the result is (S+1)>>1.
- R3: With in_mode = 2'b10 only the first row stage runs. S is the sum, over each row and c = 0..3, of |d[c]+d[c+4]| + |d[c]-d[c+4]|, and the result is (S+1)>>1.
- R4: With in_mode = 2'b11 the result is the sum of |d| over all 64 residuals, without scaling.
- R5: Pixels are 8-bit unsigned. Pixel p = 8*row + col sits at bits [8p+7:8p] of both org_pix and pred_pix. The residual is original minus predicted, taken as signed.
- R6: Each block accepted with in_valid high on a rising edge gives exactly one result, with out_valid high, 7 rising edges later. This holds in every mode, for back-to-back blocks and for blocks spaced apart.
- R7: A stage register that the block's mode does not use is not loaded. Blocks in different modes interleaved cycle by cycle still each get their own correct result.
- R8: While rst_n is low, out_valid and out_metric are 0.
- R9: Full-range inputs do not overflow. Every original pixel 255 against every predicted pixel 0 gives 8160 in modes 00, 01 and 10, and 16320 in mode 11.
- R10: out_valid stays low in every cycle that has no result due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A block is presented this cycle |
| in_mode | input | 2 | Metric select: 00 exact, 01 three columns skipped, 10 five columns skipped, 11 SAD |
| org_pix | input | 512 | 64 original pixels, 8 bits each |
| pred_pix | input | 512 | 64 predicted pixels, 8 bits each |
| out_valid | output | 1 | out_metric holds a new result |
| out_metric | output | 20 | Distortion value |

## Verification
A stage that loads when it should hold, or holds when it should load, corrupts only the result of the block passing through it. That block's out_metric is then wrong exactly 7 cycles after it was accepted, so interleaving modes on every cycle shows the fault at once. A mode that is carried wrongly, or a tap that fires at the wrong stage, shows up as the value of a different metric. The all-255 block separates all four modes through the halving, and a single-pixel impulse shows a misplaced pixel lane. Errors in the valid chain show as a result one cycle off, a missing result, or out_valid high with nothing pending.

// File: rtl/satd_pkg.sv
package satd_pkg;

  typedef enum logic [1:0] {
    MD_EXACT = 2'b00,
    MD_TRIM3 = 2'b01,
    MD_TRIM5 = 2'b10,
    MD_SAD   = 2'b11
  } metric_mode_e;

  localparam int DEF_PIX_W = 8;
  localparam int DEF_BLK_N = 8;

  // Index of the last butterfly stage a mode uses (0 = residual only).
  function automatic int last_stage(input metric_mode_e m, input int lg);
    case (m)
      MD_EXACT: return 2 * lg;
      MD_TRIM3: return lg;
      MD_TRIM5: return 1;
      default:  return 0;
    endcase
  endfunction

endpackage

// File: rtl/satd_resid.sv
module satd_resid #(
  parameter int PIX_W = 8,
  parameter int NPIX  = 64,
  parameter int DW    = 15
) (
  input  logic [NPIX*PIX_W-1:0] org,
  input  logic [NPIX*PIX_W-1:0] pred,
  output logic [NPIX*DW-1:0]    res
);

  function automatic logic signed [DW-1:0] diff(input logic [PIX_W-1:0] a,
                                                input logic [PIX_W-1:0] b);
    logic signed [DW-1:0] sa;
    logic signed [DW-1:0] sb;
    sa = {{(DW-PIX_W){1'b0}}, a};
    sb = {{(DW-PIX_W){1'b0}}, b};
    return sa - sb;
  endfunction

  for (genvar p = 0; p < NPIX; p++) begin : g_pix
    assign res[p*DW +: DW] = diff(org[p*PIX_W +: PIX_W], pred[p*PIX_W +: PIX_W]);
  end

endmodule

// File: rtl/satd_bfly_stage.sv
module satd_bfly_stage #(
  parameter int PIX_W = 8,
  parameter int BLK_N = 8,
  parameter int DW    = 15,
  parameter int STAGE = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic [BLK_N*BLK_N*DW-1:0]  d,
  output logic [BLK_N*BLK_N*DW-1:0]  q
);

  localparam int LG    = $clog2(BLK_N);
  localparam int NPIX  = BLK_N * BLK_N;
  localparam bit ROWS  = (STAGE <= LG);
  // Partner distance: along a row for stages 1..LG, down a column after.
  localparam int STEP  = ROWS ? (BLK_N >> STAGE) : ((BLK_N >> (STAGE - LG)) * BLK_N);
  localparam int BOUND = ((1 << PIX_W) - 1) << STAGE;

  logic [NPIX*DW-1:0] nxt;

  for (genvar p = 0; p < NPIX; p++) begin : g_bf
    localparam int PART = p ^ STEP;
    logic signed [DW-1:0] self_v;
    logic signed [DW-1:0] part_v;
    assign self_v = d[p*DW +: DW];
    assign part_v = d[PART*DW +: DW];
    if ((p & STEP) == 0) begin : g_sum
      assign nxt[p*DW +: DW] = self_v + part_v;
    end else begin : g_dif
      assign nxt[p*DW +: DW] = part_v - self_v;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= nxt;
  end

  function automatic logic in_range(input logic [NPIX*DW-1:0] v);
    logic signed [DW-1:0] e;
    in_range = 1'b1;
    for (int p = 0; p < NPIX; p++) begin
      e = v[p*DW +: DW];
      if (e > BOUND || e < -BOUND) in_range = 1'b0;
    end
  endfunction

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> in_range(q)); // R9

endmodule

// File: rtl/satd_abs_sum.sv
module satd_abs_sum #(
  parameter int DW   = 15,
  parameter int NPIX = 64,
  parameter int SW   = 20
) (
  input  logic [NPIX*DW-1:0] d,
  output logic [SW-1:0]      total
);

  function automatic logic [SW-1:0] abs_total(input logic [NPIX*DW-1:0] v);
    logic [SW-1:0]        acc;
    logic signed [DW-1:0] e;
    logic [DW-1:0]        mag;
    acc = '0;
    for (int p = 0; p < NPIX; p++) begin
      e   = v[p*DW +: DW];
      mag = (e < 0) ? $unsigned(-e) : $unsigned(e);
      acc = acc + SW'(mag);
    end
    return acc;
  endfunction

  assign total = abs_total(d);

endmodule

// File: rtl/satd_sad_engine.sv
module satd_sad_engine
  import satd_pkg::*;
#(
  parameter int  PIX_W = DEF_PIX_W,
  parameter int  BLK_N = DEF_BLK_N,
  localparam int OUT_W = PIX_W + 4 * $clog2(BLK_N),
  localparam int NPX   = BLK_N * BLK_N
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [1:0]         in_mode,
  input  logic [NPX*PIX_W-1:0] org_pix,
  input  logic [NPX*PIX_W-1:0] pred_pix,
  output logic               out_valid,
  output logic [OUT_W-1:0]   out_metric
);

  localparam int LG    = $clog2(BLK_N);
  localparam int NSTG  = 2 * LG;
  localparam int NPIX  = NPX;
  localparam int DW    = PIX_W + 1 + NSTG;
  localparam int LAT   = NSTG + 1;
  localparam int PMAX  = (1 << PIX_W) - 1;
  localparam int SAD_MAX  = NPIX * PMAX;
  localparam int SATD_MAX = (NPIX * NPIX * PMAX) / 2;

  function automatic logic [OUT_W-1:0] halve_round(input logic [OUT_W-1:0] s);
    logic [OUT_W:0] t;
    t = {1'b0, s} + 1'b1;
    return t[OUT_W:1];
  endfunction

  // Control pipeline: one valid bit and mode per position.
  logic [NSTG+1:0] vld;
  metric_mode_e    md [NSTG+2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      for (int k = 0; k <= NSTG + 1; k++) md[k] <= MD_EXACT;
    end else begin
      vld   <= {vld[NSTG:0], in_valid};
      md[0] <= metric_mode_e'(in_mode);
      for (int k = 1; k <= NSTG + 1; k++) md[k] <= md[k-1];
    end
  end

  // Residual register (position 0).
  logic [NPIX*DW-1:0] res_w;
  logic [NPIX*DW-1:0] res_q;
  logic [NPIX*DW-1:0] st_q [NSTG+1];

  satd_resid #(.PIX_W(PIX_W), .NPIX(NPIX), .DW(DW)) u_resid (
    .org (org_pix),
    .pred(pred_pix),
    .res (res_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        res_q <= '0;
    else if (in_valid) res_q <= res_w;
  end

  assign st_q[0] = res_q;

  // Butterfly stages: loaded only when the passing block needs them.
  logic [NSTG:1] stage_en;

  for (genvar j = 1; j <= NSTG; j++) begin : g_stage
    assign stage_en[j] = vld[j-1] && (j <= last_stage(md[j-1], LG));

    satd_bfly_stage #(.PIX_W(PIX_W), .BLK_N(BLK_N), .DW(DW), .STAGE(j)) u_stage (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (stage_en[j]),
      .d    (st_q[j-1]),
      .q    (st_q[j])
    );

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (vld[j-1] && (j > last_stage(md[j-1], LG))) |=> $stable(st_q[j])); // R7
  end

  // Taps: sum leaves the wide pipeline at the block's last stage.
  logic [NSTG:0]    tap_done;
  logic [OUT_W-1:0] tap_val [NSTG+1];

  for (genvar j = 0; j <= NSTG; j++) begin : g_tap
    if (j == 0 || j == 1 || j == LG || j == NSTG) begin : g_sum
      logic [OUT_W-1:0] raw;
      satd_abs_sum #(.DW(DW), .NPIX(NPIX), .SW(OUT_W)) u_sum (
        .d    (st_q[j]),
        .total(raw)
      );
      if (j == 0) begin : g_plain
        assign tap_val[j] = raw;
      end else begin : g_half
        assign tap_val[j] = halve_round(raw);
      end
    end else begin : g_none
      assign tap_val[j] = '0;
    end
    assign tap_done[j] = vld[j] && (last_stage(md[j], LG) == j);
  end

  // Scalar result chain, one slot per position.
  logic [OUT_W-1:0] mtr [1:NSTG+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 1; k <= NSTG + 1; k++) mtr[k] <= '0;
    end else begin
      if (vld[0]) mtr[1] <= tap_done[0] ? tap_val[0] : '0;
      for (int k = 1; k <= NSTG; k++) begin
        if (vld[k]) mtr[k+1] <= tap_done[k] ? tap_val[k] : mtr[k];
      end
    end
  end

  assign out_valid  = vld[NSTG+1];
  assign out_metric = mtr[NSTG+1];

  // Checker state: cycles since reset, saturating at the latency.
  localparam int CW = $clog2(LAT + 1);
  localparam logic [CW-1:0] LAT_C = CW'(LAT);
  logic [CW-1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= '0;
    else if (since_rst != LAT_C) since_rst <= since_rst + 1'b1;
  end

  AST_NO_EARLY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < LAT_C) |-> !out_valid); // R6

  AST_SAD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && md[NSTG+1] == MD_SAD) |-> (out_metric <= OUT_W'(SAD_MAX))); // R4

  AST_SATD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && md[NSTG+1] != MD_SAD) |-> (out_metric <= OUT_W'(SATD_MAX))); // R1

endmodule

// File: tb/satd_sad_engine_bench.sv
`timescale 1ns/1ps
module satd_sad_engine_bench;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [1:0]   in_mode;
  logic [511:0] org_pix;
  logic [511:0] pred_pix;
  logic         out_valid;
  logic [19:0]  out_metric;

  always #2 clk = ~clk;

  satd_sad_engine u_satd_sad_engine (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .org_pix(org_pix), .pred_pix(pred_pix),
    .out_valid(out_valid), .out_metric(out_metric)
  );

  typedef struct { int exp; int issue; string tag; } exp_t;
  exp_t sb[$];
  exp_t cur;
  exp_t nw;

  int og[64];
  int pr[64];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int hs(int i, int j);
    return ($countones(i & j) % 2) ? -1 : 1;
  endfunction

  function automatic int iabs(int x);
    return (x < 0) ? -x : x;
  endfunction

  // Reference metric written from the requirements (matrix form).
  function automatic int ref_metric(int m);
    int d[64];
    int s = 0;
    for (int p = 0; p < 64; p++) d[p] = og[p] - pr[p];
    if (m == 0) begin
      for (int u = 0; u < 8; u++)
        for (int v = 0; v < 8; v++) begin
          int c = 0;
          for (int r = 0; r < 8; r++)
            for (int k = 0; k < 8; k++) c += hs(u, r) * d[r*8+k] * hs(k, v);
          s += iabs(c);
        end
    end else if (m == 1) begin
      for (int r = 0; r < 8; r++)
        for (int v = 0; v < 8; v++) begin
          int c = 0;
          for (int k = 0; k < 8; k++) c += d[r*8+k] * hs(k, v);
          s += iabs(c);
        end
    end else if (m == 2) begin
      for (int r = 0; r < 8; r++)
        for (int k = 0; k < 4; k++)
          s += iabs(d[r*8+k] + d[r*8+k+4]) + iabs(d[r*8+k] - d[r*8+k+4]);
    end else begin
      for (int p = 0; p < 64; p++) s += iabs(d[p]);
      return s;
    end
    return (s + 1) / 2;
  endfunction

  task automatic send(int m, string tag);
    @(negedge clk);
    for (int p = 0; p < 64; p++) begin
      org_pix[p*8 +: 8]  = 8'(og[p]);
      pred_pix[p*8 +: 8] = 8'(pr[p]);
    end
    in_mode  = 2'(m);
    in_valid = 1'b1;
    nw.exp   = ref_metric(m);
    nw.issue = cyc + 1;
    nw.tag   = tag;
    sb.push_back(nw);
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  // Monitor: pops the scoreboard whenever a result appears.
  always @(negedge clk) begin
    if (rst_n && out_valid && !done) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R10 out_valid high with nothing due: actual metric %0d expected no result", out_metric);
      end else begin
        cur = sb.pop_front();
        if (int'(out_metric) != cur.exp) begin
          errors++;
          $display("FAIL %s: actual %0d expected %0d", cur.tag, out_metric, cur.exp);
        end
        checks++;
        if (cyc != cur.issue + 7) begin
          errors++;
          $display("FAIL R6 latency (%s): actual %0d expected %0d", cur.tag, cyc - cur.issue, 7);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL R6 watchdog expired: actual hung expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_mode = 2'b00; org_pix = '0; pred_pix = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_metric !== 20'd0) begin
      errors++;
      $display("FAIL R8 reset: actual valid %0b metric %0d expected 0 0", out_valid, out_metric);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R10 after reset: actual %0b expected 0", out_valid);
    end

    // Zero residual: every metric is 0 (R1..R4)
    for (int p = 0; p < 64; p++) begin og[p] = $urandom_range(0, 255); pr[p] = og[p]; end
    send(0, "R1 zero"); send(1, "R2 zero"); send(2, "R3 zero"); send(3, "R4 zero");
    drain();

    // Full range 255 vs 0 (R9)
    for (int p = 0; p < 64; p++) begin og[p] = 255; pr[p] = 0; end
    for (int m = 0; m < 4; m++) send(m, "R9 full range");
    drain();

    // Negative residual (R5)
    for (int p = 0; p < 64; p++) begin og[p] = 0; pr[p] = 255; end
    send(0, "R5 negative exact"); send(3, "R5 negative sad");
    drain();

    // Single-pixel impulse at row 2 col 5 (R5)
    for (int p = 0; p < 64; p++) begin og[p] = 128; pr[p] = 128; end
    og[21] = 228;
    send(0, "R5 impulse exact"); send(1, "R2 impulse"); send(2, "R3 impulse"); send(3, "R5 impulse sad");
    drain();

    // Checkerboard (R1, R2, R3)
    for (int p = 0; p < 64; p++) begin og[p] = (((p / 8) + (p % 8)) % 2) ? 255 : 0; pr[p] = 0; end
    send(0, "R1 checker"); send(1, "R2 checker"); send(2, "R3 checker");
    drain();

    // Back-to-back random blocks with modes changing every cycle (R7)
    for (int k = 0; k < 24; k++) begin
      for (int p = 0; p < 64; p++) begin og[p] = $urandom_range(0, 255); pr[p] = $urandom_range(0, 255); end
      send((k * 3 + k / 4) % 4, "R7 mixed modes");
    end
    drain();

    // Spaced-out random blocks (R6)
    for (int k = 0; k < 8; k++) begin
      for (int p = 0; p < 64; p++) begin og[p] = $urandom_range(0, 255); pr[p] = $urandom_range(0, 255); end
      send(int'($urandom_range(0, 3)), "R6 spaced");
      @(negedge clk);
      in_valid = 1'b0;
      repeat (int'($urandom_range(0, 3))) @(negedge clk);
    end
    drain();

    // Idle: no result may appear (R10)
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
        errors++;
        $display("FAIL R10 idle: actual %0b expected 0", out_valid);
      end
    end

    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R6 missing results: actual %0d pending expected 0", sb.size());
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule